// File: doc/BRIEF.md
# Program Counter with Next-Address Selection

This block holds the program counter of a processor that fetches 32-bit, word-aligned instructions. Since the two low byte-address bits are always zero, only the 30-bit word address is stored. On each enabled clock edge, the counter loads one of four candidates:

- the sequential or branch result from an adder;
- a jump target built from the upper PC bits and a 26-bit field;
- the word address held in a source register;
- a fixed entry address for system calls.

A small evaluator decides whether a conditional branch is taken. It compares the two register operands for equality or inequality, or tests the first operand's sign. The adder applies the sign-extended 16-bit offset only when that test passes. The incremented PC is always available as an output. A jump-and-link instruction stores it as its return address.

The decoder drives the 2-bit source select and the 2-bit branch kind. The register file supplies the two operands. Instruction fetch, decode and the register file are all outside the block.

Top module: `pc_next_unit`

## Requirements
- R1: While `rst_n` is low, `pc_o` reads word address 0. Reset assertion takes effect without waiting for a clock edge.
- R2: With `pc_src_i` = 00, an untaken branch and `step_en` high, the next PC is `pc_o` + 1, wrapping modulo 2^30.
- R3: With `pc_src_i` = 00 and a taken branch, the next PC is `pc_o` + 1 + `imm_i` sign-extended to 30 bits, modulo 2^30. The branch kind has no effect for any other `pc_src_i` value.
- R4: Branch kind 01 (less than zero) is taken exactly when `rs_i[31]` is 1.
- R5: Branch kind 10 (equal) is taken exactly when `rs_i` equals `rt_i`.
- R6: Branch kind 11 (not equal) is taken exactly when `rs_i` differs from `rt_i`. Branch kind 00 is never taken.
- R7: With `pc_src_i` = 01, the next PC is {`pc_o[29:26]`, `jta_i`}.
- R8: With `pc_src_i` = 10, the next PC is `rs_i[31:2]`.
- R9: With `pc_src_i` = 11, the next PC is the `SYSCALL_WADDR` parameter (default word 0x20).
- R10: `pc_inc_o` always equals `pc_o` + 1 modulo 2^30, in the same cycle.
- R11: When `step_en` is low, `pc_o` keeps its value across the clock edge.
- R12: After `rst_n` rises, the first two rising edges leave `pc_o` at 0. The third rising edge performs the first update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| step_en | input | 1 | Clock enable for the PC register |
| pc_src_i | input | 2 | Source select: 00 adder, 01 jump field, 10 register, 11 system call |
| br_kind_i | input | 2 | Branch kind: 00 none, 01 less than zero, 10 equal, 11 not equal |
| imm_i | input | 16 | Signed branch offset in words |
| jta_i | input | 26 | Jump target word field |
| rs_i | input | 32 | First register operand; also the byte address for a register jump |
| rt_i | input | 32 | Second register operand for comparisons |
| pc_o | output | 30 | Current PC word address (byte address bits 31:2) |
| pc_inc_o | output | 30 | PC word address plus one, used as the link value |

## Verification
The select, branch kind and operands presented in a cycle show up on `pc_o` right after the next rising edge, because only the PC register lies on that path. `pc_inc_o` follows `pc_o` combinationally within the same cycle. The bench drives inputs on the falling edge and samples both outputs one time unit after the rising edge. It checks against a model that advances its expected PC once per edge. Reset behaves differently on each side. Assertion is checked a moment after `rst_n` falls in mid-cycle, with no edge in between. Release is checked edge by edge, to show two edges with no update and the first update on the third edge.

// File: rtl/pcnu_pkg.sv
package pcnu_pkg;

  typedef enum logic [1:0] {
    SRC_SEQ  = 2'b00,
    SRC_JUMP = 2'b01,
    SRC_REG  = 2'b10,
    SRC_SYS  = 2'b11
  } pc_src_e;

  typedef enum logic [1:0] {
    BR_NONE = 2'b00,
    BR_LTZ  = 2'b01,
    BR_EQ   = 2'b10,
    BR_NE   = 2'b11
  } br_kind_e;

endpackage

// File: rtl/pcnu_rst_sync.sv
module pcnu_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_n_sync = sync_q[STAGES-1];

endmodule

// File: rtl/pcnu_branch_eval.sv
module pcnu_branch_eval
  import pcnu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [1:0]        kind_i,
  input  logic [DATA_W-1:0] rs_i,
  input  logic [DATA_W-1:0] rt_i,
  output logic              taken_o
);

  logic     ops_equal;
  br_kind_e kind;

  always_comb begin
    kind      = br_kind_e'(kind_i);
    ops_equal = (rs_i == rt_i);
    unique case (kind)
      BR_LTZ:  taken_o = rs_i[DATA_W-1];
      BR_EQ:   taken_o = ops_equal;
      BR_NE:   taken_o = !ops_equal;
      default: taken_o = 1'b0;
    endcase
  end

endmodule

// File: rtl/pcnu_target_sel.sv
module pcnu_target_sel
  import pcnu_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int IMM_W  = 16,
  parameter int JTA_W  = 26,
  parameter logic [ADDR_W-3:0] SYSCALL_WADDR = 30'h20
) (
  input  logic [ADDR_W-3:0] pc_i,
  input  logic [1:0]        src_i,
  input  logic              taken_i,
  input  logic [IMM_W-1:0]  imm_i,
  input  logic [JTA_W-1:0]  jta_i,
  input  logic [ADDR_W-1:0] rs_i,
  output logic [ADDR_W-3:0] inc_o,
  output logic [ADDR_W-3:0] next_o
);

  localparam int WA_W  = ADDR_W - 2;
  localparam int EXT_W = WA_W - IMM_W;
  localparam int HI_W  = WA_W - JTA_W;

  logic [WA_W-1:0] imm_ext;
  logic [WA_W-1:0] seq_or_br;
  pc_src_e         src;

  always_comb begin
    src       = pc_src_e'(src_i);
    inc_o     = pc_i + WA_W'(1);
    imm_ext   = {{EXT_W{imm_i[IMM_W-1]}}, imm_i};
    seq_or_br = taken_i ? (inc_o + imm_ext) : inc_o;
    unique case (src)
      SRC_SEQ:  next_o = seq_or_br;
      SRC_JUMP: next_o = {pc_i[WA_W-1 -: HI_W], jta_i};
      SRC_REG:  next_o = rs_i[ADDR_W-1:2];
      default:  next_o = SYSCALL_WADDR;
    endcase
  end

endmodule

// File: rtl/pc_next_unit.sv
module pc_next_unit
  import pcnu_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int IMM_W       = 16,
  parameter int JTA_W       = 26,
  parameter int SYNC_STAGES = 2,
  parameter logic [ADDR_W-3:0] RESET_WADDR   = '0,
  parameter logic [ADDR_W-3:0] SYSCALL_WADDR = 30'h20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step_en,
  input  logic [1:0]        pc_src_i,
  input  logic [1:0]        br_kind_i,
  input  logic [IMM_W-1:0]  imm_i,
  input  logic [JTA_W-1:0]  jta_i,
  input  logic [ADDR_W-1:0] rs_i,
  input  logic [ADDR_W-1:0] rt_i,
  output logic [ADDR_W-3:0] pc_o,
  output logic [ADDR_W-3:0] pc_inc_o
);

  localparam int WA_W = ADDR_W - 2;
  localparam int HI_W = WA_W - JTA_W;

  logic            rst_q_n;
  logic            br_taken;
  logic [WA_W-1:0] pc_q;
  logic [WA_W-1:0] pc_d;
  logic [WA_W-1:0] pc_next;
  logic [WA_W-1:0] pc_inc;

  pcnu_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_q_n)
  );

  pcnu_branch_eval #(.DATA_W(ADDR_W)) u_br (
    .kind_i  (br_kind_i),
    .rs_i    (rs_i),
    .rt_i    (rt_i),
    .taken_o (br_taken)
  );

  pcnu_target_sel #(
    .ADDR_W        (ADDR_W),
    .IMM_W         (IMM_W),
    .JTA_W         (JTA_W),
    .SYSCALL_WADDR (SYSCALL_WADDR)
  ) u_sel (
    .pc_i    (pc_q),
    .src_i   (pc_src_i),
    .taken_i (br_taken),
    .imm_i   (imm_i),
    .jta_i   (jta_i),
    .rs_i    (rs_i),
    .inc_o   (pc_inc),
    .next_o  (pc_next)
  );

  always_comb begin
    pc_d = step_en ? pc_next : pc_q;
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      pc_q <= RESET_WADDR;
    end else begin
      pc_q <= pc_d;
    end
  end

  assign pc_o     = pc_q;
  assign pc_inc_o = pc_inc;

  // Checking aids: the offset is extended here independently of u_sel.
  logic [WA_W-1:0] chk_off;
  assign chk_off = WA_W'($signed(imm_i));

  assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_q_n)
    !step_en |=> $stable(pc_q));

  assert_seq_R2: assert property (@(posedge clk) disable iff (!rst_q_n)
    step_en && pc_src_i == SRC_SEQ && !br_taken |=> pc_q == $past(pc_inc));

  assert_branch_R3: assert property (@(posedge clk) disable iff (!rst_q_n)
    step_en && pc_src_i == SRC_SEQ && br_taken
    |=> pc_q == $past(pc_q) + WA_W'(1) + $past(chk_off));

  assert_jump_R7: assert property (@(posedge clk) disable iff (!rst_q_n)
    step_en && pc_src_i == SRC_JUMP
    |=> pc_q[WA_W-1 -: HI_W] == $past(pc_q[WA_W-1 -: HI_W])
        && pc_q[JTA_W-1:0] == $past(jta_i));

  assert_reg_R8: assert property (@(posedge clk) disable iff (!rst_q_n)
    step_en && pc_src_i == SRC_REG |=> pc_q == $past(rs_i[ADDR_W-1:2]));

  assert_sys_R9: assert property (@(posedge clk) disable iff (!rst_q_n)
    step_en && pc_src_i == SRC_SYS |=> pc_q == SYSCALL_WADDR);

  assert_nobranch_R6: assert property (@(posedge clk) disable iff (!rst_q_n)
    br_kind_i == BR_NONE |-> !br_taken);

endmodule

// File: tb/tb_pc_next_unit.sv
module tb_pc_next_unit;

  localparam int CLK_PERIOD = 10;
  localparam logic [29:0] SYS_W = 30'h20;

  logic        clk;
  logic        rst_n;
  logic        step_en;
  logic [1:0]  pc_src_i;
  logic [1:0]  br_kind_i;
  logic [15:0] imm_i;
  logic [25:0] jta_i;
  logic [31:0] rs_i;
  logic [31:0] rt_i;
  logic [29:0] pc_o;
  logic [29:0] pc_inc_o;

  int total = 0;
  int bad   = 0;
  logic [29:0] exp_pc;

  pc_next_unit dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .step_en   (step_en),
    .pc_src_i  (pc_src_i),
    .br_kind_i (br_kind_i),
    .imm_i     (imm_i),
    .jta_i     (jta_i),
    .rs_i      (rs_i),
    .rt_i      (rt_i),
    .pc_o      (pc_o),
    .pc_inc_o  (pc_inc_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input logic [29:0] act, input logic [29:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic brtaken(input logic [1:0] kind, input logic [31:0] rs, input logic [31:0] rt);
    case (kind)
      2'b01:   return rs[31];
      2'b10:   return rs == rt;
      2'b11:   return rs != rt;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [29:0] model(input logic [29:0] pc, input logic [1:0] src,
      input logic [1:0] kind, input logic [15:0] imm, input logic [25:0] jta,
      input logic [31:0] rs, input logic [31:0] rt);
    logic [29:0] inc;
    inc = pc + 30'd1;
    case (src)
      2'b00:   return brtaken(kind, rs, rt) ? inc + {{14{imm[15]}}, imm} : inc;
      2'b01:   return {pc[29:26], jta};
      2'b10:   return rs[31:2];
      default: return SYS_W;
    endcase
  endfunction

  function automatic string tag_of(input logic [1:0] src, input logic [1:0] kind);
    if (src == 2'b01) return "R7";
    if (src == 2'b10) return "R8";
    if (src == 2'b11) return "R9";
    case (kind)
      2'b01:   return "R4/R3";
      2'b10:   return "R5/R3";
      2'b11:   return "R6/R3";
      default: return "R2/R6";
    endcase
  endfunction

  task automatic step(input logic en, input logic [1:0] src, input logic [1:0] kind,
      input logic [15:0] imm, input logic [25:0] jta, input logic [31:0] rs,
      input logic [31:0] rt, input string tag);
    @(negedge clk);
    step_en = en; pc_src_i = src; br_kind_i = kind;
    imm_i = imm; jta_i = jta; rs_i = rs; rt_i = rt;
    if (en) exp_pc = model(exp_pc, src, kind, imm, jta, rs, rt);
    @(posedge clk);
    #1;
    check(tag, pc_o, exp_pc);
    check("R10", pc_inc_o, exp_pc + 30'd1);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    bad++; total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] seeds [8];
    logic [15:0] imms  [8];
    seeds = '{32'h0000_0000, 32'h0000_0100, 32'hFFFF_FFFC, 32'h7FFF_FFFC,
              32'h8000_0000, 32'h1234_5678, 32'hF000_0040, 32'h3FFF_FFF0};
    imms  = '{16'h0000, 16'h0001, 16'hFFFF, 16'h7FFF, 16'h8000, 16'h0123, 16'hFF00, 16'h0010};
    rst_n = 1'b0; step_en = 1'b0; pc_src_i = 2'b00; br_kind_i = 2'b00;
    imm_i = '0; jta_i = '0; rs_i = '0; rt_i = '0;
    exp_pc = '0;
    repeat (3) @(posedge clk);
    #1;
    check("R1", pc_o, 30'd0);

    // R12: release; step_en high with sequential select
    @(negedge clk);
    rst_n = 1'b1; step_en = 1'b1;
    @(posedge clk); #1; check("R12", pc_o, 30'd0);
    @(posedge clk); #1; check("R12", pc_o, 30'd0);
    @(posedge clk); #1; check("R12", pc_o, 30'd1);
    exp_pc = 30'd1;

    // Sweep: seed PC via register jump, then apply each select/kind/relation
    for (int s = 0; s < 8; s++) begin
      for (int src = 0; src < 4; src++) begin
        for (int kind = 0; kind < 4; kind++) begin
          for (int rel = 0; rel < 3; rel++) begin
            logic [31:0] rs;
            logic [31:0] rt;
            rt = 32'h0000_1230 ^ seeds[s];
            if (rel == 0)      rs = rt;
            else if (rel == 1) rs = rt | 32'h8000_0000;
            else               rs = (rt & 32'h7FFF_FFFF) ^ 32'h0000_0004;
            if (rs == rt && rel != 0) rs = rs ^ 32'h10;
            step(1'b1, 2'b10, 2'b11, 16'h0, 26'h0, seeds[s], 32'h0, "R8");
            step(1'b1, 2'(src), 2'(kind), imms[s], 26'h2AB_CDEF ^ 26'(s), rs, rt,
                 tag_of(2'(src), 2'(kind)));
          end
        end
      end
    end

    // R2 wrap at top of the word space
    step(1'b1, 2'b10, 2'b00, 16'h0, 26'h0, 32'hFFFF_FFFC, 32'h0, "R8");
    step(1'b1, 2'b00, 2'b00, 16'h0, 26'h0, 32'h0, 32'h0, "R2 wrap");
    check("R2 wrap", pc_o, 30'd0);

    // R11: hold with every select driven
    for (int src = 0; src < 4; src++) begin
      step(1'b0, 2'(src), 2'b10, 16'h0040, 26'h155_5555, 32'h8765_4320, 32'h8765_4320, "R11");
    end

    // R1: asynchronous assertion mid-cycle
    step(1'b1, 2'b10, 2'b00, 16'h0, 26'h0, 32'h0000_4440, 32'h0, "R8");
    @(negedge clk);
    #2 rst_n = 1'b0;
    #1 check("R1 async", pc_o, 30'd0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule